// File: doc/BRIEF.md
# CRT Sync Output Conditioner

This block sits between a display timing generator and the CRT connector. It takes the generator's raw horizontal sync, vertical sync and blank levels. For each output it applies an enable and a polarity taken from a control register. The enables let power-management software hold any output quiet. The vertical sync pin can instead carry a serial clock bit that software toggles.

The block also keeps a vertical interrupt flag. The flag latches on the start of each vertical sync pulse while interrupts are enabled.

A timing-enable bit does two things. It locks a small bank of timing registers against writes. When it is cleared, it holds the dot-clock logic in reset and masks the raw timing inputs. Software reaches the control register and the timing registers through a write-enable/address/data port.

Top module: `crt_sync_cond`

## Requirements
- R1: With its enable set, a sync output follows its raw input when its polarity bit is 0. It follows the inverse of the raw input when the polarity bit is 1. Control register (address 0) bits: 0 horizontal enable, 1 vertical enable, 2 blank enable, 3 horizontal polarity, 4 vertical polarity, 5 interrupt enable, 6 timing enable, 7 serial clock.
- R2: With its enable bit 0, the horizontal sync output is held low whatever its polarity bit. The vertical sync output is held low as well, provided the serial clock bit is 0.
- R3: With blank enable set, the active-low blank output is low exactly while the raw blank input is high. With blank enable 0 it is held low.
- R4: While the vertical enable bit is 0, the vertical sync pin carries the serial clock bit. While the vertical enable bit is 1, the serial clock bit has no effect on the pin.
- R5: While interrupt enable and timing enable are both 1, a rising edge of the raw vertical sync sets the interrupt flag. The flag then stays set with no further sync edges.
- R6: While interrupt enable is 0, the interrupt flag is cleared and stays clear.
- R7: The timing registers sit at addresses 1 to N_TREG. Register k appears on bits [16k-1:16(k-1)] of the timing output. A write to one of them takes effect only while timing enable is 0. Writes made while timing enable is 1 are ignored.
- R8: While timing enable is 0, the dot-clock reset output is high. The raw sync and blank inputs are then treated as inactive, so each enabled output sits at its idle level.
- R9: Every output is registered. A control write changes the pins at the second rising edge after the write is presented. A raw input change shows at the pins after one rising edge.
- R10: After reset, control and timing registers are zero, all sync and blank outputs are low, the interrupt flag is clear and dot-clock reset is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address: 0 control, 1..N_TREG timing registers |
| wr_data_i | input | DATA_W | Write data |
| raw_hsync_i | input | 1 | Raw horizontal sync level from the timing generator |
| raw_vsync_i | input | 1 | Raw vertical sync level from the timing generator |
| raw_blank_i | input | 1 | Raw blank level, high during blanking |
| hsync_o | output | 1 | Conditioned horizontal sync pin |
| vsync_o | output | 1 | Conditioned vertical sync or serial clock pin |
| blank_n_o | output | 1 | Conditioned active-low blank pin |
| vint_o | output | 1 | Latched vertical interrupt flag |
| dot_rst_o | output | 1 | Reset for the dot-clock logic |
| tmg_regs_o | output | N_TREG*DATA_W | Contents of the timing registers |

## Verification
Some properties are checked by assertions on every cycle:
- a disabled output staying low, or carrying the serial clock bit;
- an enabled output idling at its polarity, including while timing enable is off;
- the interrupt flag clearing when its enable is off and holding while it is on;
- the timing registers staying stable while they are locked.

Other properties only the bench scenarios can show:
- that every combination of enables, polarities and serial clock level yields the right pin levels for changing raw inputs;
- that the interrupt sets on a sync edge;
- the exact two-edge latency of a control write.

The bench shows these by comparison against a behavioural model on every cycle.

// File: rtl/crt_sync_pkg.sv
package crt_sync_pkg;

    // Control register layout, MSB first.
    typedef struct packed {
        logic serclk;
        logic tg_en;
        logic irq_en;
        logic vs_pol;
        logic hs_pol;
        logic blank_en;
        logic vs_en;
        logic hs_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam int LANE_H = 0;
    localparam int LANE_V = 1;
    localparam int LANE_B = 2;
    localparam int N_LANE = 3;

endpackage

// File: rtl/crt_ctrl_regs.sv
module crt_ctrl_regs
    import crt_sync_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16,
    parameter int N_TREG = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [ADDR_W-1:0]        wr_addr_i,
    input  logic [DATA_W-1:0]        wr_data_i,
    output ctrl_t                    ctrl_o,
    output logic [N_TREG*DATA_W-1:0] treg_o
);

    typedef struct packed {
        ctrl_t                          ctrl;
        logic [N_TREG-1:0][DATA_W-1:0]  treg;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            if (wr_addr_i == '0) begin
                st_d.ctrl = ctrl_t'(wr_data_i[CTRL_W-1:0]);
            end
            for (int i = 0; i < N_TREG; i++) begin
                if (wr_addr_i == ADDR_W'(i + 1) && !st_q.ctrl.tg_en) begin
                    st_d.treg[i] = wr_data_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o = st_q.ctrl;

    for (genvar g = 0; g < N_TREG; g++) begin : g_treg
        assign treg_o[g*DATA_W +: DATA_W] = st_q.treg[g];

        assert_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.ctrl.tg_en |=> $stable(treg_o[g*DATA_W +: DATA_W]));
    end

endmodule

// File: rtl/crt_sync_lane.sv
module crt_sync_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic raw_i,
    input  logic en_i,
    input  logic pol_i,
    input  logic alt_i,
    output logic pin_o
);

    logic lvl;
    logic pin_d, pin_q;

    always_comb begin
        lvl   = raw_i & ~hold_i;
        pin_d = en_i ? (lvl ^ pol_i) : alt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_d;
    end

    assign pin_o = pin_q;

    assert_off_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !alt_i) |=> !pin_o);

    assert_alt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> pin_o == $past(alt_i));

    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !raw_i) |=> pin_o == $past(pol_i));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && hold_i) |=> pin_o == $past(pol_i));

endmodule

// File: rtl/crt_vint.sv
module crt_vint (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic vs_raw_i,
    input  logic irq_en_i,
    output logic irq_o
);

    typedef struct packed {
        logic prev;
        logic flag;
    } st_t;

    st_t  st_d, st_q;
    logic v_int;

    always_comb begin
        v_int   = vs_raw_i & run_i;
        st_d    = st_q;
        st_d.prev = v_int;
        if (!irq_en_i)                 st_d.flag = 1'b0;
        else if (v_int && !st_q.prev)  st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.flag;

    assert_vint_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_i |=> !irq_o);

    assert_vint_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en_i && irq_o) |=> irq_o);

endmodule

// File: rtl/crt_sync_cond.sv
module crt_sync_cond
    import crt_sync_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16,
    parameter int N_TREG = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [ADDR_W-1:0]        wr_addr_i,
    input  logic [DATA_W-1:0]        wr_data_i,
    input  logic                     raw_hsync_i,
    input  logic                     raw_vsync_i,
    input  logic                     raw_blank_i,
    output logic                     hsync_o,
    output logic                     vsync_o,
    output logic                     blank_n_o,
    output logic                     vint_o,
    output logic                     dot_rst_o,
    output logic [N_TREG*DATA_W-1:0] tmg_regs_o
);

    ctrl_t             ctrl;
    logic [N_LANE-1:0] raw_v, en_v, pol_v, alt_v, pin_v;

    crt_ctrl_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .N_TREG (N_TREG)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .ctrl_o    (ctrl),
        .treg_o    (tmg_regs_o)
    );

    // Blank uses a fixed inverting polarity to make it active low.
    always_comb begin
        raw_v[LANE_H] = raw_hsync_i;
        en_v[LANE_H]  = ctrl.hs_en;
        pol_v[LANE_H] = ctrl.hs_pol;
        alt_v[LANE_H] = 1'b0;
        raw_v[LANE_V] = raw_vsync_i;
        en_v[LANE_V]  = ctrl.vs_en;
        pol_v[LANE_V] = ctrl.vs_pol;
        alt_v[LANE_V] = ctrl.serclk;
        raw_v[LANE_B] = raw_blank_i;
        en_v[LANE_B]  = ctrl.blank_en;
        pol_v[LANE_B] = 1'b1;
        alt_v[LANE_B] = 1'b0;
    end

    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        crt_sync_lane u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .hold_i (~ctrl.tg_en),
            .raw_i  (raw_v[g]),
            .en_i   (en_v[g]),
            .pol_i  (pol_v[g]),
            .alt_i  (alt_v[g]),
            .pin_o  (pin_v[g])
        );
    end

    crt_vint u_vint (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (ctrl.tg_en),
        .vs_raw_i (raw_vsync_i),
        .irq_en_i (ctrl.irq_en),
        .irq_o    (vint_o)
    );

    assign hsync_o   = pin_v[LANE_H];
    assign vsync_o   = pin_v[LANE_V];
    assign blank_n_o = pin_v[LANE_B];
    assign dot_rst_o = ~ctrl.tg_en;

endmodule

// File: tb/crt_sync_cond_bench.sv
module crt_sync_cond_bench;

    localparam int AW = 3;
    localparam int DW = 16;
    localparam int NT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic raw_h = 1'b0, raw_v = 1'b0, raw_b = 1'b0;
    logic hs, vs, bn, vint, drst;
    logic [NT*DW-1:0] tregs;

    int checks = 0;
    int errors = 0;
    bit started = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    crt_sync_cond #(.ADDR_W(AW), .DATA_W(DW), .N_TREG(NT)) u_crt_sync_cond (
        .clk (clk), .rst_n (rst_n), .wr_en_i (wr_en), .wr_addr_i (wr_addr),
        .wr_data_i (wr_data), .raw_hsync_i (raw_h), .raw_vsync_i (raw_v),
        .raw_blank_i (raw_b), .hsync_o (hs), .vsync_o (vs), .blank_n_o (bn),
        .vint_o (vint), .dot_rst_o (drst), .tmg_regs_o (tregs)
    );

    // Behavioural reference model
    logic [7:0]  m_ctrl;
    logic [15:0] m_treg [NT];
    bit m_hs, m_vs, m_bn, m_irq, m_prev;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl = 8'h00;
            for (int i = 0; i < NT; i++) m_treg[i] = 16'h0;
            m_hs = 0; m_vs = 0; m_bn = 0; m_irq = 0; m_prev = 0;
        end else begin
            bit th, tv, tb, rise;
            th = raw_h && m_ctrl[6];
            tv = raw_v && m_ctrl[6];
            tb = raw_b && m_ctrl[6];
            m_hs = m_ctrl[0] ? (th != m_ctrl[3]) : 1'b0;
            m_vs = m_ctrl[1] ? (tv != m_ctrl[4]) : m_ctrl[7];
            m_bn = m_ctrl[2] ? !tb : 1'b0;
            rise = tv && !m_prev;
            m_prev = tv;
            if (!m_ctrl[5]) m_irq = 0;
            else if (rise)  m_irq = 1;
            if (wr_en) begin
                if (wr_addr == 0) m_ctrl = wr_data[7:0];
                else if (int'(wr_addr) <= NT && !m_ctrl[6])
                    m_treg[int'(wr_addr) - 1] = wr_data;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && rst_n) begin
            chk(hs == m_hs, "R1 R2 hsync model", hs, m_hs);
            chk(vs == m_vs, "R1 R4 vsync model", vs, m_vs);
            chk(bn == m_bn, "R3 blank model", bn, m_bn);
            chk(vint == m_irq, "R5 R6 interrupt model", vint, m_irq);
            chk(drst == !m_ctrl[6], "R8 dot reset model", drst, !m_ctrl[6]);
            for (int i = 0; i < NT; i++)
                chk(tregs[i*DW +: DW] == m_treg[i], "R7 timing reg model",
                    tregs[i*DW +: DW], m_treg[i]);
        end
    end

    function automatic logic [15:0] mk(bit hse, bit vse, bit ble, bit hp, bit vp,
                                       bit ie, bit tg, bit sc);
        return {8'h00, sc, tg, ie, vp, hp, ble, vse, hse};
    endfunction

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            raw_h = lfsr[0]; raw_v = lfsr[3] & lfsr[5]; raw_b = lfsr[7];
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(hs == 0 && vs == 0 && bn == 0, "R10 sync/blank low", {hs, vs, bn}, 0);
        chk(vint == 0, "R10 interrupt clear", vint, 0);
        chk(drst == 1, "R10 dot reset high", drst, 1);
        chk(tregs == '0, "R10 timing regs zero", int'(tregs[31:0]), 0);
        rst_n = 1'b1;
        started = 1'b1;

        // R7 unlocked writes
        for (int i = 1; i <= NT; i++) wr(i, 16'(i * 16'h1111));
        chk(tregs[DW +: DW] == 16'h2222, "R7 unlocked write", tregs[DW +: DW], 16'h2222);

        // R1 R2 R3 R4 all enable/polarity/serial clock combinations
        for (int c = 0; c < 64; c++) begin
            wr(0, mk(c[0], c[1], c[2], c[3], c[4], (c % 3) != 0, 1'b1, c[5]));
            run(10);
            wr(0, mk(c[0], c[1], c[2], c[3], c[4], (c % 3) != 0, 1'b1, !c[5]));
            run(6);
        end

        // R9 latency of a polarity change
        raw_h = 0; raw_v = 0; raw_b = 0;
        wr(0, mk(1, 1, 1, 0, 0, 0, 1, 0));
        @(negedge clk);
        wr(0, mk(1, 1, 1, 1, 0, 0, 1, 0));
        chk(hs == 0, "R9 no change one edge after write", hs, 0);
        @(negedge clk);
        chk(hs == 1, "R9 change two edges after write", hs, 1);

        // R4 serial clock on vsync pin
        wr(0, mk(1, 0, 1, 0, 0, 0, 1, 1));
        @(negedge clk);
        chk(vs == 1, "R4 serial clock high", vs, 1);
        wr(0, mk(1, 0, 1, 0, 0, 0, 1, 0));
        @(negedge clk);
        chk(vs == 0, "R4 serial clock low", vs, 0);
        wr(0, mk(1, 1, 1, 0, 1, 0, 1, 0));
        @(negedge clk);
        wr(0, mk(1, 1, 1, 0, 1, 0, 1, 1));
        @(negedge clk);
        chk(vs == 1, "R4 serial clock ignored when enabled", vs, 1);

        // R5 / R6 interrupt
        wr(0, mk(1, 1, 1, 0, 0, 1, 1, 0));
        @(negedge clk);
        raw_v = 1;
        @(negedge clk);
        chk(vint == 1, "R5 set on vsync edge", vint, 1);
        raw_v = 0;
        repeat (3) @(negedge clk);
        chk(vint == 1, "R5 flag holds", vint, 1);
        wr(0, mk(1, 1, 1, 0, 0, 0, 1, 0));
        @(negedge clk);
        chk(vint == 0, "R6 cleared by enable low", vint, 0);
        raw_v = 1;
        repeat (2) @(negedge clk);
        chk(vint == 0, "R6 stays clear", vint, 0);
        raw_v = 0;

        // R7 locked writes ignored
        wr(2, 16'hBEEF);
        @(negedge clk);
        chk(tregs[DW +: DW] == 16'h2222, "R7 locked write ignored", tregs[DW +: DW], 16'h2222);

        // R8 timing disabled
        wr(0, mk(1, 1, 1, 0, 1, 0, 0, 0));
        raw_h = 1; raw_v = 1; raw_b = 1;
        repeat (2) @(negedge clk);
        chk(drst == 1, "R8 dot reset high", drst, 1);
        chk(hs == 0, "R8 hsync idle", hs, 0);
        chk(vs == 1, "R8 vsync idle at polarity", vs, 1);
        chk(bn == 1, "R8 blank inactive", bn, 1);
        wr(2, 16'hBEEF);
        @(negedge clk);
        chk(tregs[DW +: DW] == 16'hBEEF, "R7 write after unlock", tregs[DW +: DW], 16'hBEEF);
        run(40);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule